// File: doc/BRIEF.md
# Bit-Masked GPIO Port Register File

This block is an 8-pin general-purpose I/O port that hangs off a simple memory-mapped register bus. Its distinguishing feature is the pin data register. It has no single address: it answers across a whole 1 KB window, and the word-address bits of each access form a per-bit mask. Software can therefore set, clear or sample any subset of pins in one bus cycle, with no read-modify-write sequence and no risk of disturbing pins that another agent owns.

Each pin has a direction bit. When the bit is set, the pin drives its output latch onto the pad. When it is clear, the pin samples the pad through a two-stage synchronizer. A separate 8-bit sense register is stored and read back as plain configuration for an external interrupt unit. Read data is registered, so it returns one clock after the read strobe. Writes take effect on the clock edge that carries the write strobe.

Top module: `gpio_masked_port`

## Requirements
- R1: After a synchronous active-low reset, the direction, output latch and sense registers are all zero. `pad_oe`, `pad_out` and `bus_rdata` are 0, so every pin starts as an input.
- R2: Every address from 0x000 to 0x3FF reaches the same data register. The access mask is `bus_addr[9:2]`, where address bit 2 gates data bit 0 and address bit 9 gates data bit 7.
- R3: On a write to the data window, each latch bit whose mask bit is 1 takes the written value. Each latch bit whose mask bit is 0 keeps its previous value.
- R4: On a read of the data window, each bit whose mask bit is 0 returns 0. Each bit whose mask bit is 1 returns that pin's current value.
- R5: A pin's value is its output latch bit when its direction bit is 1. It is its synchronized pad input when its direction bit is 0.
- R6: A pad change placed before clock edge k does not appear on a read strobed at edge k or k+1. It does appear on a read strobed at edge k+2.
- R7: The direction register answers at 0x400 (address bits [1:0] ignored) and can be read and written in full. `pad_oe` equals this register, and a 1 means output.
- R8: `pad_out` always equals the output latch. A write to the latch of an input pin updates the latch, and that value reaches the pad once the direction bit is set.
- R9: The sense register answers at 0x404, and every bit written there reads back unchanged.
- R10: Offsets 0x408 to 0xFFF read as 0, and writes to them change no register.
- R11: `bus_rdata` loads one clock after a read strobe and holds its value while no read is strobed. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_out | output | 8 | Per-pin output value (the latch) |
| pad_in | input | 8 | Per-pin input from the pads |

## Verification
The data window is driven with a full mask, with low-nibble and high-nibble masks, and with single-bit masks. This separates a swapped or shifted mask from a correct one and catches a write that touches unmasked bits. Reads are issued with all pins as outputs, with a split direction, and with all pins as inputs, which shows whether latch and pad are selected per pin. A pad change with back-to-back reads pins down the synchronizer depth exactly. A combined read and write of one register, together with unmapped writes followed by read-back of every register, exposes decode aliasing and ordering faults.

// File: rtl/gpio_port_pkg.sv
// Package: shared register-select encoding for the masked GPIO port.
// Assumes: one select is active per access; REG_NONE covers unmapped space.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_DATA  = 2'd1,
        REG_DIR   = 2'd2,
        REG_SENSE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Maps a byte address onto a register select and the per-bit data mask.
// Assumes: the data window spans the low 2**(WIDTH+2) bytes, the direction and
// sense registers sit at the next two word slots, and ADDR_W > WIDTH+2.
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [WIDTH-1:0]  mask
);
    localparam int WIN_BITS = WIDTH + 2;
    localparam int IDX_W    = ADDR_W - 2;
    localparam logic [IDX_W-1:0] DIR_IDX   = IDX_W'(1) << (WIN_BITS - 2);
    localparam logic [IDX_W-1:0] SENSE_IDX = DIR_IDX + IDX_W'(1);

    logic [IDX_W-1:0] word_idx;

    assign word_idx = addr[ADDR_W-1:2];
    assign mask     = addr[WIN_BITS-1:2];

    // Classify the access by word index; the whole low window is the data register.
    always_comb begin
        if (addr[ADDR_W-1:WIN_BITS] == '0)
            sel = REG_DATA;
        else if (word_idx == DIR_IDX)
            sel = REG_DIR;
        else if (word_idx == SENSE_IDX)
            sel = REG_SENSE;
        else
            sel = REG_NONE;
    end
endmodule

// File: rtl/gpio_input_sync.sv
// Module: gpio_input_sync
// Multi-stage synchronizer that carries the asynchronous pad inputs into the clock domain.
// Assumes: each pin is independent; multi-bit coherence is not required.
module gpio_input_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage [STAGES];

    // First stage captures the raw pad value.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage resamples the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stage[i] <= '0;
            else        stage[i] <= stage[i-1];
        end
    end

    assign q_sync = stage[STAGES-1];
endmodule

// File: rtl/gpio_masked_port.sv
// Module: gpio_masked_port
// GPIO port with an address-masked data window, a direction register and a
// stored sense register. Read data is registered; writes land on the strobe edge.
// Assumes: bus_rd and bus_wr are single-cycle strobes; pad_in is asynchronous.
module gpio_masked_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    input  logic [WIDTH-1:0]  pad_in
);
    reg_sel_e         dec_sel;
    logic [WIDTH-1:0] dec_mask;
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] dir_q, latch_q, sense_q;
    logic [WIDTH-1:0] pin_val, rd_val;

    gpio_addr_decode #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (dec_sel),
        .mask (dec_mask)
    );

    gpio_input_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pad_sync)
    );

    // Output latch: masked merge of write data on data-window writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (bus_wr && dec_sel == REG_DATA)
            latch_q <= (latch_q & ~dec_mask) | (bus_wdata & dec_mask);
    end

    // Direction and sense registers: plain full-width writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
        end else if (bus_wr) begin
            if (dec_sel == REG_DIR)   dir_q   <= bus_wdata;
            if (dec_sel == REG_SENSE) sense_q <= bus_wdata;
        end
    end

    // Per-pin value: latch for outputs, synchronized pad for inputs.
    assign pin_val = (dir_q & latch_q) | (~dir_q & pad_sync);

    // Read multiplexer over the selected register.
    always_comb begin
        unique case (dec_sel)
            REG_DATA:  rd_val = pin_val & dec_mask;
            REG_DIR:   rd_val = dir_q;
            REG_SENSE: rd_val = sense_q;
            default:   rd_val = '0;
        endcase
    end

    // Read data register: loads only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    assign pad_oe  = dir_q;
    assign pad_out = latch_q;

    // R3: latch bits outside the write mask never move on a data write.
    a_r3_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_sel == REG_DATA) |=> ((pad_out ^ $past(pad_out)) & ~$past(dec_mask)) == '0);

    // R7: a direction write shows up on pad_oe on the next cycle.
    a_r7_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_sel == REG_DIR) |=> pad_oe == $past(bus_wdata));

    // R10: a read of unmapped space returns zero.
    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && dec_sel == REG_NONE) |=> bus_rdata == '0);

    // R10: unmapped writes leave the pad-facing registers alone.
    a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && dec_sel == REG_NONE) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R11: read data holds while no read is strobed.
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sim_gpio_masked_port.sv
`timescale 1ns/1ps
module sim_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_oe, pad_out;
    logic [7:0]  pad_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_q = 1'b0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    gpio_masked_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Driver: one bus cycle; read expectations go to the scoreboard queue.
    task automatic bus_op(input logic w, input logic r, input logic [11:0] a,
                          input logic [7:0] d, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        if (r) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    // Monitor: note which edges carried a read strobe.
    always @(posedge clk) rd_q <= bus_rd;

    // Monitor: compare registered read data half a cycle after the strobe edge.
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R11: unexpected read result %02h", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1: reset state
        chk(pad_oe, 8'h00, "R1 pad_oe");
        chk(pad_out, 8'h00, "R1 pad_out");
        chk(bus_rdata, 8'h00, "R1 rdata");
        bus_op(0, 1, 12'h400, 0, 8'h00, "R1 dir");
        bus_op(0, 1, 12'h404, 0, 8'h00, "R1 sense");

        // R7: all outputs
        bus_op(1, 0, 12'h400, 8'hFF, 0, "");
        bus_op(0, 1, 12'h401, 0, 8'hFF, "R7 dir readback");
        idle();
        chk(pad_oe, 8'hFF, "R7 pad_oe");

        // R2/R3: full-mask write, then nibble masks
        bus_op(1, 0, 12'h3FC, 8'hA5, 0, "");
        bus_op(0, 1, 12'h3FC, 0, 8'hA5, "R2 full mask read");
        bus_op(1, 0, 12'h03C, 8'hFF, 0, "");
        idle();
        chk(pad_out, 8'hAF, "R3 low-nibble set");
        bus_op(1, 0, 12'h3C0, 8'h00, 0, "");
        idle();
        chk(pad_out, 8'h0F, "R3 high-nibble clear");

        // R4: masked reads of latch 0x0F
        bus_op(0, 1, 12'h00C, 0, 8'h03, "R4 mask 03");
        bus_op(0, 1, 12'h0C0, 0, 8'h00, "R4 mask 30");
        bus_op(0, 1, 12'h200, 0, 8'h00, "R2 bit9 gates bit7");

        // R5: split direction
        pad_in = 8'h5A;
        bus_op(1, 0, 12'h400, 8'hF0, 0, "");
        idle(); idle();
        bus_op(0, 1, 12'h3FC, 0, 8'h0A, "R5 split direction");
        bus_op(0, 1, 12'h008, 0, 8'h02, "R4 input bit masked");

        // R8: latch write on an input pin
        bus_op(1, 0, 12'h004, 8'h00, 0, "");
        idle();
        chk(pad_out, 8'h0E, "R8 latch of input pin");
        chk(pad_oe, 8'hF0, "R8 pin still input");
        bus_op(1, 0, 12'h400, 8'hFF, 0, "");
        bus_op(0, 1, 12'h3FC, 0, 8'h0E, "R8 value after direction set");

        // R9: sense register
        bus_op(1, 0, 12'h404, 8'h3C, 0, "");
        bus_op(0, 1, 12'h404, 0, 8'h3C, "R9 sense readback");
        bus_op(0, 1, 12'h400, 0, 8'hFF, "R9 dir untouched");

        // R10: unmapped space
        bus_op(1, 0, 12'h408, 8'hFF, 0, "");
        bus_op(1, 0, 12'hFFC, 8'h00, 0, "");
        bus_op(0, 1, 12'h408, 0, 8'h00, "R10 unmapped read");
        bus_op(0, 1, 12'h400, 0, 8'hFF, "R10 dir kept");
        bus_op(0, 1, 12'h404, 0, 8'h3C, "R10 sense kept");
        bus_op(0, 1, 12'h3FC, 0, 8'h0E, "R10 latch kept");

        // R11: hold and read-during-write
        idle(); idle(); idle();
        chk(bus_rdata, 8'h0E, "R11 rdata hold");
        bus_op(1, 1, 12'h400, 8'h00, 8'hFF, "R11 read sees pre-write");
        bus_op(0, 1, 12'h400, 0, 8'h00, "R11 write landed");

        // R6: two-stage synchronizer latency (all pins inputs, pad 0x5A)
        idle(); idle();
        bus_op(0, 1, 12'h3FC, 0, 8'h5A, "R6 edge k");
        pad_in = 8'h33;
        bus_op(0, 1, 12'h3FC, 0, 8'h5A, "R6 edge k+1");
        bus_op(0, 1, 12'h3FC, 0, 8'h33, "R6 edge k+2");

        idle(); idle(); idle();
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R11: actual %0d pending reads expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule